// File: doc/BRIEF.md
# Aligned-Start 64b/66b Block Encoder

This block turns a wide media-independent transmit stream into 66-bit line blocks. Every 64-bit word of the input comes with eight per-byte control flags. The block encodes each word on its own into one 66-bit block, which is a 2-bit sync header followed by a 64-bit payload. A control block also carries a block-type byte at the bottom of its payload. The default build accepts four words (256 bits) per clock and produces four blocks per clock, one register stage later.

A packet may begin only in byte 0 of a word. Because of this, the encoder never produces the block types that place a start or an ordered set in the upper half of a word. A start character found in any other byte lane, or any control mix the encoder does not recognise, produces a full error block. Scrambling, lane distribution and alignment markers are handled downstream.

Byte lane i of word w is `in_data[64w+8i +: 8]`, and its flag is `in_ctrl[8w+i]`. Block w is `out_blocks[66w +: 66]`. The sync header sits in bits [1:0] and payload bit j sits in block bit j+2. The recognised control characters are idle 0x07, start 0xFB, terminate 0xFD and error 0xFE.

Top module: `enc66_restricted_start`

## Requirements
- R1: A word whose eight control flags are all clear yields sync header 2'b01, and its payload equals the 64 input data bits unchanged.
- R2: Every control block carries sync header 2'b10 with its type byte in payload bits [7:0]. While `out_valid` is high, no block carries any sync header other than 2'b01 or 2'b10.
- R3: A word of eight control lanes that all hold idle (0x07) yields type 0x1E, with all eight 7-bit control codes equal to 0x00.
- R4: In a word of eight control lanes that each hold idle or error (0xFE), lane i's 7-bit code sits at payload bits [8+7i +: 7]. That code is 0x00 for idle and 0x1E for error, and the type byte is 0x1E.
- R5: Flags 0x01 with 0xFB in lane 0 yield type 0x78, with input bytes 1 to 7 in payload bits [63:8].
- R6: A terminate (0xFD) in lane k, with data in the lanes below k and idle in every lane above k, yields a type byte that depends on k. The types for k = 0 to 7 are 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF. Input byte j (j < k) sits at payload [8+8j +: 8], and all other payload bits are zero.
- R7: A start character flagged in any lane other than 0 yields the error block: type 0x1E with all eight codes 0x1E.
- R8: Any other control mix yields the same error block. This covers an unknown control character, a non-idle lane after a terminate, and a start mixed with other control lanes.
- R9: No control block ever carries type 0x2D, 0x33, 0x66 or 0x55.
- R10: `out_valid` equals the previous cycle's `in_valid`. Each block depends only on its own input word. While `in_valid` is low, `out_blocks` holds its value.
- R11: After reset, `out_valid` is 0 and `out_blocks` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input words are present this cycle |
| in_data | input | NUM_WORDS*64 | Data bytes, word 0 in the low bits |
| in_ctrl | input | NUM_WORDS*8 | Per-byte control flags |
| out_valid | output | 1 | Blocks registered from a valid input |
| out_blocks | output | NUM_WORDS*66 | Encoded blocks, block 0 in the low bits |

## Verification
The hardest cases to reach from the ports are near-legal words. One is a terminate whose trailing lanes are all control but not all idle. Another is a start character sitting in a non-zero lane of a word in a non-zero slot. A third is a start that shares its word with other control lanes. The stimulus sweeps each terminate position and each misaligned start lane across all four word slots in directed cycles. It then runs a long stretch in which every slot independently draws one of eight pattern kinds, including these near-legal ones. Each output is compared with a behavioural reference on every clock.

// File: rtl/enc66_pkg.sv
package enc66_pkg;

    localparam int WORD_BYTES = 8;
    localparam int WORD_BITS  = 64;
    localparam int BLK_BITS   = 66;

    localparam logic [7:0] CH_IDLE  = 8'h07;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;
    localparam logic [7:0] CH_ERR   = 8'hFE;

    localparam logic [7:0] BT_CTRL  = 8'h1E;
    localparam logic [7:0] BT_START = 8'h78;

    localparam logic [6:0] CC_IDLE  = 7'h00;
    localparam logic [6:0] CC_ERR   = 7'h1E;

    localparam logic [1:0] SH_DATA  = 2'b01;
    localparam logic [1:0] SH_CTRL  = 2'b10;

    typedef enum logic [2:0] {
        K_DATA,
        K_CTRL,
        K_START,
        K_TERM,
        K_BAD
    } blk_kind_e;

    typedef struct packed {
        blk_kind_e  kind;
        logic [2:0] term_pos;
    } word_class_t;

    typedef struct packed {
        logic [63:0] payload;
        logic [1:0]  sync;
    } blk66_t;

    function automatic logic [7:0] term_type(input logic [2:0] pos);
        case (pos)
            3'd0:    return 8'h87;
            3'd1:    return 8'h99;
            3'd2:    return 8'hAA;
            3'd3:    return 8'hB4;
            3'd4:    return 8'hCC;
            3'd5:    return 8'hD2;
            3'd6:    return 8'hE1;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [6:0] ctrl_code(input logic [7:0] ch);
        return (ch == CH_IDLE) ? CC_IDLE : CC_ERR;
    endfunction

    function automatic logic [63:0] error_payload();
        logic [63:0] p;
        p[7:0] = BT_CTRL;
        for (int i = 0; i < WORD_BYTES; i++) begin
            p[8+7*i +: 7] = CC_ERR;
        end
        return p;
    endfunction

endpackage

// File: rtl/enc66_word_classify.sv
module enc66_word_classify
    import enc66_pkg::*;
(
    input  logic [63:0]  word_data,
    input  logic [7:0]   word_ctrl,
    output word_class_t  word_class
);

    logic [WORD_BYTES-1:0] is_idle;
    logic [WORD_BYTES-1:0] is_err;
    logic [WORD_BYTES-1:0] is_term;
    logic                  start_lane0;

    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        logic [7:0] ch;
        assign ch         = word_data[8*i +: 8];
        assign is_idle[i] = word_ctrl[i] && (ch == CH_IDLE);
        assign is_err[i]  = word_ctrl[i] && (ch == CH_ERR);
        assign is_term[i] = word_ctrl[i] && (ch == CH_TERM);
    end

    assign start_lane0 = (word_ctrl == 8'h01) && (word_data[7:0] == CH_START);

    logic [2:0] first_ctrl;
    logic       trail_idle;
    logic       term_ok;
    logic       all_plain;

    always_comb begin
        first_ctrl = 3'd0;
        for (int i = WORD_BYTES - 1; i >= 0; i--) begin
            if (word_ctrl[i]) begin
                first_ctrl = 3'(i);
            end
        end
        trail_idle = 1'b1;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (i > int'(first_ctrl) && !is_idle[i]) begin
                trail_idle = 1'b0;
            end
        end
        term_ok   = is_term[first_ctrl] && trail_idle;
        all_plain = &(is_idle | is_err);
    end

    always_comb begin
        word_class.term_pos = first_ctrl;
        if (word_ctrl == 8'h00) begin
            word_class.kind = K_DATA;
        end else if (start_lane0) begin
            word_class.kind = K_START;
        end else if (all_plain) begin
            word_class.kind = K_CTRL;
        end else if (term_ok) begin
            word_class.kind = K_TERM;
        end else begin
            word_class.kind = K_BAD;
        end
    end

endmodule

// File: rtl/enc66_word_build.sv
module enc66_word_build
    import enc66_pkg::*;
(
    input  logic [63:0]  word_data,
    input  word_class_t  word_class,
    output blk66_t       blk
);

    logic [63:0] ctrl_payload;
    logic [63:0] term_payload;

    always_comb begin
        ctrl_payload[7:0] = BT_CTRL;
        for (int i = 0; i < WORD_BYTES; i++) begin
            ctrl_payload[8+7*i +: 7] = ctrl_code(word_data[8*i +: 8]);
        end
    end

    always_comb begin
        term_payload      = '0;
        term_payload[7:0] = term_type(word_class.term_pos);
        for (int j = 0; j < WORD_BYTES - 1; j++) begin
            if (j < int'(word_class.term_pos)) begin
                term_payload[8+8*j +: 8] = word_data[8*j +: 8];
            end
        end
        for (int m = 1; m < WORD_BYTES; m++) begin
            if (m > int'(word_class.term_pos)) begin
                term_payload[8+7*m +: 7] = CC_IDLE;
            end
        end
    end

    always_comb begin
        case (word_class.kind)
            K_DATA: begin
                blk.sync    = SH_DATA;
                blk.payload = word_data;
            end
            K_CTRL: begin
                blk.sync    = SH_CTRL;
                blk.payload = ctrl_payload;
            end
            K_START: begin
                blk.sync    = SH_CTRL;
                blk.payload = {word_data[63:8], BT_START};
            end
            K_TERM: begin
                blk.sync    = SH_CTRL;
                blk.payload = term_payload;
            end
            default: begin
                blk.sync    = SH_CTRL;
                blk.payload = error_payload();
            end
        endcase
    end

endmodule

// File: rtl/enc66_restricted_start.sv
module enc66_restricted_start
    import enc66_pkg::*;
#(
    parameter int NUM_WORDS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [NUM_WORDS*64-1:0]       in_data,
    input  logic [NUM_WORDS*8-1:0]        in_ctrl,
    output logic                          out_valid,
    output logic [NUM_WORDS*66-1:0]       out_blocks
);

    localparam int IN_BITS  = NUM_WORDS * WORD_BITS;
    localparam int OUT_BITS = NUM_WORDS * BLK_BITS;

    logic [OUT_BITS-1:0] next_blocks;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        word_class_t cls;
        blk66_t      blk;

        enc66_word_classify u_cls (
            .word_data  (in_data[w*WORD_BITS +: WORD_BITS]),
            .word_ctrl  (in_ctrl[w*WORD_BYTES +: WORD_BYTES]),
            .word_class (cls)
        );

        enc66_word_build u_bld (
            .word_data  (in_data[w*WORD_BITS +: WORD_BITS]),
            .word_class (cls),
            .blk        (blk)
        );

        assign next_blocks[w*BLK_BITS +: BLK_BITS] = blk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_blocks <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_blocks <= next_blocks;
            end
        end
    end

    logic unused_width_ok;
    assign unused_width_ok = (IN_BITS == $bits(in_data));

endmodule

// File: rtl/enc66_checker.sv
module enc66_checker #(
    parameter int NUM_WORDS = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [NUM_WORDS*64-1:0] in_data,
    input logic [NUM_WORDS*8-1:0]  in_ctrl,
    input logic                    out_valid,
    input logic [NUM_WORDS*66-1:0] out_blocks
);

    localparam logic [65:0] ERR_BLK = {{8{7'h1E}}, 8'h1E, 2'b10};

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && out_blocks == '0)); // R11

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid))); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_blocks)); // R10

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_chk
        logic [65:0] blk;
        assign blk = out_blocks[66*w +: 66];

        AST_SYNC_LEGAL: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (blk[1:0] == 2'b01 || blk[1:0] == 2'b10)); // R2

        AST_DATA_PASS: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ctrl[8*w +: 8] == 8'h00)
            |=> (blk == {$past(in_data[64*w +: 64]), 2'b01})); // R1

        AST_NO_HIGH_START: assert property (@(posedge clk) disable iff (rst)
            (out_valid && blk[1:0] == 2'b10)
            |-> !(blk[9:2] inside {8'h2D, 8'h33, 8'h66, 8'h55})); // R9

        AST_MISALIGNED_START: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ctrl[8*w +: 8] == 8'h10 && in_data[64*w+32 +: 8] == 8'hFB)
            |=> (blk == ERR_BLK)); // R7
    end

endmodule

bind enc66_restricted_start enc66_checker #(.NUM_WORDS(NUM_WORDS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ctrl    (in_ctrl),
    .out_valid  (out_valid),
    .out_blocks (out_blocks)
);

// File: tb/enc66_restricted_start_tb.sv
module enc66_restricted_start_tb_top;

    localparam int  NW         = 4;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [NW*64-1:0]  in_data = '0;
    logic [NW*8-1:0]   in_ctrl = '0;
    logic              out_valid;
    logic [NW*66-1:0]  out_blocks;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic              exp_valid = 1'b0;
    logic [NW*66-1:0]  exp_blocks = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc66_restricted_start #(.NUM_WORDS(NW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ctrl    (in_ctrl),
        .out_valid  (out_valid),
        .out_blocks (out_blocks)
    );

    localparam logic [63:0] ERR_PAY = {{8{7'h1E}}, 8'h1E};

    function automatic logic [7:0] ref_term_type(int k);
        logic [7:0] t [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
        return t[k];
    endfunction

    function automatic logic [65:0] ref_block(logic [63:0] d, logic [7:0] c);
        logic [63:0] p;
        bit ok;
        int k;
        if (c == 8'h00) return {d, 2'b01};
        if (c == 8'h01 && d[7:0] == 8'hFB) return {d[63:8], 8'h78, 2'b10};
        if (c == 8'hFF) begin
            ok = 1;
            p  = 64'h1E;
            for (int i = 0; i < 8; i++) begin
                if (d[8*i +: 8] == 8'hFE) p[8+7*i +: 7] = 7'h1E;
                else if (d[8*i +: 8] != 8'h07) ok = 0;
            end
            if (ok) return {p, 2'b10};
        end
        k = 0;
        while (!c[k]) k++;
        ok = (d[8*k +: 8] == 8'hFD);
        for (int i = k + 1; i < 8; i++) begin
            if (!(c[i] && d[8*i +: 8] == 8'h07)) ok = 0;
        end
        if (ok) begin
            p = '0;
            for (int i = 0; i < k; i++) p[8+8*i +: 8] = d[8*i +: 8];
            p[7:0] = ref_term_type(k);
            return {p, 2'b10};
        end
        return {ERR_PAY, 2'b10};
    endfunction

    task automatic check66(bit cond, string tag, logic [65:0] act, logic [65:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one cycle after a negedge, compare at the next negedge
    task automatic step(logic v, logic [NW*64-1:0] d, logic [NW*8-1:0] c, string tag);
        logic [65:0] a;
        logic [65:0] e;
        in_valid = v;
        in_data  = d;
        in_ctrl  = c;
        exp_valid = v;
        if (v) begin
            for (int w = 0; w < NW; w++)
                exp_blocks[66*w +: 66] = ref_block(d[64*w +: 64], c[8*w +: 8]);
        end
        @(negedge clk);
        check66(out_valid == exp_valid, {tag, " R10 valid"}, 66'(out_valid), 66'(exp_valid));
        for (int w = 0; w < NW; w++) begin
            a = out_blocks[66*w +: 66];
            e = exp_blocks[66*w +: 66];
            check66(a === e, tag, a, e);
            if (out_valid) begin
                check66(a[1:0] == 2'b01 || a[1:0] == 2'b10, "R2 sync header", a, e);
                check66(!(a[1:0] == 2'b10 && a[9:2] inside {8'h2D, 8'h33, 8'h66, 8'h55}),
                        "R9 forbidden type", a, e);
            end
        end
    endtask

    function automatic logic [63:0] idle_word();
        return {8{8'h07}};
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // term in lane k, data below, idle above
    function automatic logic [63:0] term_word(logic [63:0] d, int k);
        logic [63:0] r = d;
        r[8*k +: 8] = 8'hFD;
        for (int i = k + 1; i < 8; i++) r[8*i +: 8] = 8'h07;
        return r;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] d;
        logic [NW*64-1:0] bd;
        logic [NW*8-1:0]  bc;
        repeat (3) @(negedge clk);
        check66(out_valid == 1'b0 && out_blocks == '0, "R11 reset state",
                66'(out_valid), 66'd0);
        rst = 1'b0;

        // R1: data patterns
        step(1, '0, '0, "R1 all zero data");
        step(1, {NW{64'hFFFF_FFFF_FFFF_FFFF}}, '0, "R1 all ones data");
        step(1, {rnd64(), rnd64(), rnd64(), rnd64()}, '0, "R1 random data");

        // R3 / R4
        step(1, {NW{idle_word()}}, {NW{8'hFF}}, "R3 all idle");
        step(1, {NW{64'hFE07_07FE_0707_FEFE}}, {NW{8'hFF}}, "R4 idle/error mix");
        step(1, {NW{{8{8'hFE}}}}, {NW{8'hFF}}, "R4 all error");

        // R5
        d = rnd64(); d[7:0] = 8'hFB;
        step(1, {NW{d}}, {NW{8'h01}}, "R5 aligned start");

        // R6: every terminate position, in every slot
        for (int k = 0; k < 8; k++) begin
            d = term_word(rnd64(), k);
            step(1, {NW{d}}, {NW{8'(8'hFF << k)}}, $sformatf("R6 terminate k=%0d", k));
        end

        // R7: misaligned start in each lane 1..7
        for (int k = 1; k < 8; k++) begin
            d = rnd64(); d[8*k +: 8] = 8'hFB;
            step(1, {NW{d}}, {NW{8'(1 << k)}}, $sformatf("R7 start lane %0d", k));
        end

        // R8: assorted illegal mixes
        d = idle_word(); d[7:0] = 8'h9C;
        step(1, {NW{d}}, {NW{8'hFF}}, "R8 unknown control char");
        d = term_word(rnd64(), 3); d[47:40] = 8'hFE;
        step(1, {NW{d}}, {NW{8'hF8}}, "R8 error after terminate");
        d = idle_word(); d[7:0] = 8'hFB;
        step(1, {NW{d}}, {NW{8'hFF}}, "R8 start with control lanes");
        d = rnd64(); d[23:16] = 8'hFD;
        step(1, {NW{d}}, {NW{8'h04}}, "R8 terminate data above");

        // R10: mixed slots, then hold while invalid
        d = rnd64(); d[7:0] = 8'hFB;
        bd = {term_word(rnd64(), 5), d, idle_word(), rnd64()};
        bc = {8'hE0, 8'h01, 8'hFF, 8'h00};
        step(1, bd, bc, "R10 mixed slots");
        step(0, {NW{rnd64()}}, {NW{8'hFF}}, "R10 hold while invalid");
        step(0, '0, '0, "R10 hold second cycle");

        // R10: random per-slot mix
        for (int n = 0; n < 400; n++) begin
            for (int w = 0; w < NW; w++) begin
                int kind = $urandom_range(0, 7);
                int k    = $urandom_range(0, 7);
                d = rnd64();
                case (kind)
                    0: bc[8*w +: 8] = 8'h00;
                    1: begin d = idle_word(); bc[8*w +: 8] = 8'hFF; end
                    2: begin d[7:0] = 8'hFB; bc[8*w +: 8] = 8'h01; end
                    3: begin d = term_word(d, k); bc[8*w +: 8] = 8'(8'hFF << k); end
                    4: begin d = {8{8'hFE}}; d[8*k +: 8] = 8'h07; bc[8*w +: 8] = 8'hFF; end
                    5: begin d[8*k +: 8] = 8'hFB; bc[8*w +: 8] = 8'(1 << k); end
                    6: begin d = term_word(d, k); d[63:56] = 8'hFE; bc[8*w +: 8] = 8'(8'hFF << k); end
                    default: bc[8*w +: 8] = 8'($urandom());
                endcase
                bd[64*w +: 64] = d;
            end
            step(($urandom_range(0, 5) != 0), bd, bc, "R10 random mix");
        end

        // R11: reset again clears outputs
        rst = 1'b1;
        @(negedge clk);
        check66(out_valid == 1'b0 && out_blocks == '0, "R11 reset clears",
                66'(out_valid), 66'd0);
        rst = 1'b0;
        exp_valid = 1'b0;
        exp_blocks = '0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule